// File: doc/BRIEF.md
# Throttled Background Read Command Generator

This block produces a steady, shaped stream of memory read commands so that a chip can be loaded with background traffic while another unit's throughput is measured. One transfer covers a single contiguous byte range: a base address and a length of up to 4096 bytes. The block splits the range into read commands. No command is larger than a selected maximum burst, and the last command carries whatever bytes remain. After each accepted command it can hold off for a programmed number of idle cycles. That lets software trade the stream's bandwidth against its burst shape.

When the last command of a transfer is accepted, the block emits a completion pulse. It then reloads the configuration inputs and starts again from the base address, so the load keeps running until the enable input is dropped. Commands use a valid/ready handshake. A command that has been offered stays unchanged until the memory port accepts it.

The controller has three states. IDLE waits for a start pulse. ISSUE drives a command. GAP counts the idle cycles. The named transitions are:
- IDLE→ISSUE on an accepted start.
- ISSUE→ISSUE on an accept when the rate is zero.
- ISSUE→GAP on an accept when the rate is non-zero.
- ISSUE→IDLE on an accept when enable is low, or when the final command completes and no restart is possible.
- GAP→ISSUE when the counter reaches its last idle cycle.
- GAP→IDLE when enable is low.

Top module: `bgload_rdcmd_gen`

## Requirements
- R1: After reset, `cmd_valid` and `done_pulse` are low, and they stay low until a start pulse arrives with `enable` high.
- R2: The burst select code maps to a burst of 16 << code bytes, so codes 0, 1, 2 and 3 give 16, 32, 64 and 128. Each command's `cmd_bytes` equals the smaller of the bytes remaining and that burst.
- R3: The first command of a transfer is at the base address. Each following command's address is the previous address plus the previous byte count. A length that is not a multiple of the burst ends with a shorter command carrying the remainder.
- R4: With a rate value r from 0 to 7, `cmd_valid` is low for exactly r cycles after an accept and then rises again. With r = 0, commands are issued back-to-back.
- R5: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_addr` and `cmd_bytes` hold their values.
- R6: When the final command is accepted with `enable` high and a non-zero length, the next transfer starts at the base address with the full length reloaded. This repeats indefinitely.
- R7: `done_pulse` is high for one cycle, in the cycle that follows the accept of each transfer's final command, and at no other time.
- R8: The base, length, burst select and rate are sampled only when a transfer starts. Changing them in the middle of a transfer has no effect until the next restart.
- R9: If `enable` drops while a command is offered, that command is still held until it is accepted. After the accept, `cmd_valid` goes low and stays low. If `enable` drops during a gap, the generator goes idle.
- R10: A start pulse is ignored when `enable` is low, when the length is zero, or while a transfer is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows issuing and restarting; low stops after the command in flight |
| start | input | 1 | One-cycle pulse that begins the first transfer |
| cfg_base | input | ADDR_W | Source base address |
| cfg_len | input | LEN_W | Transfer length in bytes (1 to MAX_LEN) |
| cfg_bsel | input | BSEL_W | Burst size code |
| cfg_rate | input | RATE_W | Idle cycles inserted after each accept |
| cmd_ready | input | 1 | Memory port accepts the offered command |
| cmd_valid | output | 1 | A read command is offered |
| cmd_addr | output | ADDR_W | Byte address of the offered command |
| cmd_bytes | output | CNT_W | Byte count of the offered command |
| done_pulse | output | 1 | One-cycle pulse after a transfer's last accept |

## Verification
A wrong remaining-byte count or address register first shows on `cmd_addr` or `cmd_bytes` at the next offered command, within one gap of the fault. A count that misses zero also shows, because `done_pulse` then fails to appear in the cycle after the expected final accept. A gap counter that is off by one shows as a wrong number of low cycles on `cmd_valid` between two commands. A state register that ignores `enable` or `start` shows within a cycle or two, as `cmd_valid` rising when it must stay low.

// File: rtl/bgload_pkg.sv
package bgload_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_GAP   = 2'd2
    } gen_state_e;

endpackage

// File: rtl/bgload_chunk_calc.sv
module bgload_chunk_calc #(
    parameter int LEN_W      = 13,
    parameter int BSEL_W     = 2,
    parameter int CNT_W      = 8,
    parameter int BASE_BURST = 16
) (
    input  logic [BSEL_W-1:0] bsel,
    input  logic [LEN_W-1:0]  rem,
    output logic [LEN_W-1:0]  burst,
    output logic [CNT_W-1:0]  bytes
);
    localparam int NSEL = 1 << BSEL_W;

    logic [LEN_W-1:0] burst_tab [NSEL];

    // one entry per burst code: BASE_BURST doubled per step
    for (genvar g = 0; g < NSEL; g++) begin : g_burst
        assign burst_tab[g] = LEN_W'(BASE_BURST << g);
    end

    assign burst = burst_tab[bsel];
    assign bytes = CNT_W'((rem < burst) ? rem : burst);

endmodule

// File: rtl/bgload_gap_timer.sv
module bgload_gap_timer #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [RATE_W-1:0] load_val,
    output logic              last
);
    logic [RATE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == RATE_W'(1));

    // R4
    gap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cnt == '0));

endmodule

// File: rtl/bgload_xfer_track.sv
module bgload_xfer_track #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13,
    parameter int BSEL_W = 2,
    parameter int RATE_W = 3,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [BSEL_W-1:0] cfg_bsel,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic [CNT_W-1:0]  step_bytes,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  rem,
    output logic [BSEL_W-1:0] bsel_q,
    output logic [RATE_W-1:0] rate_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            rem    <= '0;
            bsel_q <= '0;
            rate_q <= '0;
        end else if (load) begin
            addr   <= cfg_base;
            rem    <= cfg_len;
            bsel_q <= cfg_bsel;
            rate_q <= cfg_rate;
        end else if (advance) begin
            addr <= addr + ADDR_W'(step_bytes);
            rem  <= rem - LEN_W'(step_bytes);
        end
    end

    // R3
    advance_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (rem != '0));

endmodule

// File: rtl/bgload_rdcmd_gen.sv
module bgload_rdcmd_gen
    import bgload_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAX_LEN    = 4096,
    parameter int BASE_BURST = 16,
    parameter int BSEL_W     = 2,
    parameter int RATE_W     = 3,
    localparam int LEN_W     = $clog2(MAX_LEN + 1),
    localparam int MAX_BURST = BASE_BURST << ((1 << BSEL_W) - 1),
    localparam int CNT_W     = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [BSEL_W-1:0] cfg_bsel,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              cmd_ready,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [CNT_W-1:0]  cmd_bytes,
    output logic              done_pulse
);
    gen_state_e state, nxt_state;

    logic [LEN_W-1:0]  trk_rem;
    logic [BSEL_W-1:0] bsel_q;
    logic [RATE_W-1:0] rate_q;
    logic [LEN_W-1:0]  burst_w;
    logic              accept, is_final, start_ok, chain_ok;
    logic              trk_load, trk_advance;
    logic              gap_load, gap_clear, gap_last;
    logic              done_q;

    assign accept      = cmd_valid && cmd_ready;
    assign is_final    = accept && (trk_rem == LEN_W'(cmd_bytes));
    assign start_ok    = (state == ST_IDLE) && start && enable && (cfg_len != '0);
    assign chain_ok    = is_final && enable && (cfg_len != '0);
    assign trk_load    = start_ok || chain_ok;
    assign trk_advance = accept && !is_final;
    assign gap_load    = accept && (nxt_state == ST_GAP);
    assign gap_clear   = (state == ST_GAP) && !enable;

    bgload_xfer_track #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .BSEL_W (BSEL_W),
        .RATE_W (RATE_W),
        .CNT_W  (CNT_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (trk_load),
        .advance    (trk_advance),
        .cfg_base   (cfg_base),
        .cfg_len    (cfg_len),
        .cfg_bsel   (cfg_bsel),
        .cfg_rate   (cfg_rate),
        .step_bytes (cmd_bytes),
        .addr       (cmd_addr),
        .rem        (trk_rem),
        .bsel_q     (bsel_q),
        .rate_q     (rate_q)
    );

    bgload_chunk_calc #(
        .LEN_W      (LEN_W),
        .BSEL_W     (BSEL_W),
        .CNT_W      (CNT_W),
        .BASE_BURST (BASE_BURST)
    ) u_chunk (
        .bsel  (bsel_q),
        .rem   (trk_rem),
        .burst (burst_w),
        .bytes (cmd_bytes)
    );

    bgload_gap_timer #(
        .RATE_W (RATE_W)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (gap_clear),
        .load     (gap_load),
        .load_val (rate_q),
        .last     (gap_last)
    );

    // next-state decision
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: begin
                if (start_ok) nxt_state = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (accept) begin
                    if (!enable || (is_final && !chain_ok)) nxt_state = ST_IDLE;
                    else if (rate_q == '0)                  nxt_state = ST_ISSUE;
                    else                                    nxt_state = ST_GAP;
                end
            end
            ST_GAP: begin
                if (!enable)       nxt_state = ST_IDLE;
                else if (gap_last) nxt_state = ST_ISSUE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= is_final;
    end

    assign cmd_valid  = (state == ST_ISSUE);
    assign done_pulse = done_q;

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_addr) && $stable(cmd_bytes)));

    // R2
    bytes_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((cmd_bytes != '0) && (LEN_W'(cmd_bytes) <= burst_w)));

    // R4
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && enable && (rate_q != '0)) |=> !cmd_valid);

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !enable) |=> !cmd_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !enable) |=> !cmd_valid);

    // R7
    done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(accept));

endmodule

// File: tb/bgload_rdcmd_gen_test.sv
module bgload_rdcmd_gen_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        start;
    logic [31:0] cfg_base;
    logic [12:0] cfg_len;
    logic [1:0]  cfg_bsel;
    logic [2:0]  cfg_rate;
    logic        cmd_ready;
    logic        cmd_valid;
    logic [31:0] cmd_addr;
    logic [7:0]  cmd_bytes;
    logic        done_pulse;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bgload_rdcmd_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .start      (start),
        .cfg_base   (cfg_base),
        .cfg_len    (cfg_len),
        .cfg_bsel   (cfg_bsel),
        .cfg_rate   (cfg_rate),
        .cmd_ready  (cmd_ready),
        .cmd_valid  (cmd_valid),
        .cmd_addr   (cmd_addr),
        .cmd_bytes  (cmd_bytes),
        .done_pulse (done_pulse)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    // runs nx transfers; bsel_next is applied mid-transfer after the first accept
    task automatic run_xfers(input logic [31:0] base, input int len,
                             input logic [1:0] bsel, input logic [1:0] bsel_next,
                             input int rate, input int nx, input bit stall);
        int rem, burst, idle, done_n, cyc, b;
        logic [31:0] ea;
        bit exp_done, after_acc;
        @(negedge clk);
        cfg_base = base; cfg_len = 13'(len); cfg_bsel = bsel; cfg_rate = 3'(rate);
        enable = 1'b1; cmd_ready = 1'b0;
        pulse_start();
        ea = base; rem = len; burst = 16 << bsel;
        done_n = 0; cyc = 0; idle = 0; exp_done = 0; after_acc = 0;
        while (done_n < nx && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            cmd_ready = stall ? (cyc % 3 != 0) : 1'b1;
            check(done_pulse == exp_done, "R7", "done_pulse", done_pulse, exp_done);
            exp_done = 0;
            if (cmd_valid) begin
                if (after_acc) begin
                    check(idle == rate, "R4", "idle cycles before command", idle, rate);
                    after_acc = 0;
                end
                b = (rem < burst) ? rem : burst;
                check(cmd_addr == ea, "R3", "command address", cmd_addr, ea);
                check(cmd_bytes == b, "R2", "command byte count", cmd_bytes, b);
                if (cmd_ready) begin
                    ea = ea + b; rem = rem - b; after_acc = 1; idle = 0;
                    if (rem != 0) cfg_bsel = bsel_next; // R8 mid-transfer change
                    if (rem == 0) begin
                        done_n++; exp_done = 1;
                        ea = base; rem = len; burst = 16 << cfg_bsel; // R6 restart
                    end
                end
            end else begin
                idle++;
            end
        end
        check(done_n == nx, "R6", "transfers completed", done_n, nx);
    endtask

    task automatic halt();
        int n;
        @(negedge clk);
        enable = 1'b0; cmd_ready = 1'b1;
        n = 0;
        while (cmd_valid && n < 16) begin @(negedge clk); n++; end
        for (int i = 0; i < 8; i++) begin
            check(!cmd_valid, "R9", "valid after disable", cmd_valid, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        enable = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!cmd_valid, "R1", "valid before start", cmd_valid, 0);
            check(!done_pulse, "R1", "done before start", done_pulse, 0);
        end
        enable = 1'b0;
    endtask

    task automatic t_enable_stop();
        @(negedge clk);
        cfg_base = 32'h0000_4000; cfg_len = 13'd64; cfg_bsel = 2'd0; cfg_rate = 3'd0;
        enable = 1'b1; cmd_ready = 1'b0;
        pulse_start();
        @(negedge clk);
        check(cmd_valid, "R9", "valid offered", cmd_valid, 1);
        enable = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(cmd_valid, "R9", "in-flight held", cmd_valid, 1);
            check(cmd_addr == 32'h4000, "R5", "held address", cmd_addr, 32'h4000);
            check(cmd_bytes == 8'd16, "R5", "held bytes", cmd_bytes, 16);
        end
        cmd_ready = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!cmd_valid, "R9", "valid after in-flight accept", cmd_valid, 0);
        end
    endtask

    task automatic t_start_ignored();
        // enable low
        @(negedge clk);
        cfg_len = 13'd64; enable = 1'b0;
        pulse_start();
        repeat (3) begin
            @(negedge clk);
            check(!cmd_valid, "R10", "start with enable low", cmd_valid, 0);
        end
        // zero length
        cfg_len = 13'd0; enable = 1'b1;
        pulse_start();
        repeat (3) begin
            @(negedge clk);
            check(!cmd_valid, "R10", "start with zero length", cmd_valid, 0);
        end
        // start while running
        cfg_base = 32'h0000_6000; cfg_len = 13'd128; cfg_bsel = 2'd0; cfg_rate = 3'd0;
        cmd_ready = 1'b1;
        pulse_start();
        @(negedge clk);
        check(cmd_addr == 32'h6000, "R3", "first address", cmd_addr, 32'h6000);
        @(negedge clk);
        check(cmd_addr == 32'h6010, "R3", "second address", cmd_addr, 32'h6010);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cmd_addr == 32'h6020, "R10", "start while running", cmd_addr, 32'h6020);
        halt();
    endtask

    initial begin
        rst_n = 1'b0; enable = 1'b0; start = 1'b0; cmd_ready = 1'b0;
        cfg_base = '0; cfg_len = '0; cfg_bsel = '0; cfg_rate = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        t_reset();
        run_xfers(32'h0000_1000, 64, 2'd0, 2'd0, 0, 3, 1'b0); halt();   // back-to-back
        run_xfers(32'h2000_0040, 100, 2'd1, 2'd1, 2, 2, 1'b0); halt();  // remainder
        run_xfers(32'h8000_0000, 4096, 2'd3, 2'd3, 4, 2, 1'b0); halt(); // full size
        run_xfers(32'h0010_0000, 4096, 2'd0, 2'd0, 0, 1, 1'b0); halt();
        run_xfers(32'h0000_0300, 96, 2'd2, 2'd2, 7, 3, 1'b1); halt();   // stalls
        run_xfers(32'h0000_0500, 64, 2'd0, 2'd3, 1, 2, 1'b0); halt();   // R8
        for (int r = 1; r < 7; r++) begin
            run_xfers(32'h0000_0800, 48, 2'd0, 2'd0, r, 1, 1'b0); halt();
        end
        t_enable_stop();
        t_start_ignored();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule